// File: doc/BRIEF.md
# Maskable Input Change Interrupt Unit

This block watches a bank of general-purpose input pins and keeps one sticky change flag for each of them. A flag is set whenever its synchronized input changes level, in either direction, and it stays set until the host next accesses the device over the serial bus. A mask register decides which inputs may also assert a latched, active-low, open-drain interrupt line. The interrupt stays asserted until the host's next access, whether that access is a read or a write.

The serial protocol engine sits beside this block. It sends a single-cycle pulse when a bus access completes, and a load strobe with data when the host writes the mask. It also forwards a bus-abort line, which cancels whatever transaction is in flight. The block presents the flag byte, the live synchronized input byte and the interrupt pin.

The power-up reset `rst` is synchronous and active high. While it is asserted, the change detector takes the current pin levels as its baseline, so levels that are already present at reset release do not raise flags.

Top module: `tdet_unit`

## Requirements
- R1: After reset, `flags_o` is 0, `irq_n_o` is released (high impedance), and the mask is all ones, so every input is enabled for the interrupt.
- R2: `live_o` equals `pins_i` delayed by two clock edges, through a two-flop synchronizer.
- R3: A level change on input bit i sets bit i of `flags_o` three clock edges after it is applied at `pins_i`. The flag stays set until a clear, including when the input changes back.
- R4: A cycle with `access_i` = 1 and `abort_i` = 0 clears all flags and releases `irq_n_o` at the next edge.
- R5: A change that is detected in the same cycle as a clear is kept. After that edge, `flags_o` holds exactly the bits that changed in that cycle.
- R6: A change on input i while mask bit i is 1 drives `irq_n_o` to 0 at the same edge that sets the flag. `irq_n_o` then stays 0 until a clear.
- R7: A change on input i while mask bit i is 0 sets flag i but does not assert `irq_n_o`.
- R8: A cycle with `mask_we_i` = 1 and `abort_i` = 0 loads `mask_wdata_i` into the mask. Bit i set to 1 enables input i for the interrupt.
- R9: While `abort_i` = 1, both `access_i` and `mask_we_i` are ignored. The flags, the interrupt state and the mask all keep their values.
- R10: `irq_n_o` is only ever driven to 0 or released to high impedance. It is never driven to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| pins_i | input | W | Asynchronous input pins |
| access_i | input | 1 | Single-cycle pulse when a bus access (read or write) completes |
| mask_we_i | input | 1 | Mask load strobe |
| mask_wdata_i | input | W | New mask value |
| abort_i | input | 1 | Bus abort; cancels this cycle's access and mask load |
| flags_o | output | W | Sticky change flags |
| live_o | output | W | Synchronized input levels |
| irq_n_o | output | 1 | Open-drain interrupt: 0 when asserted, Z when released |

## Verification
The embedded assertions watch the cycle-to-cycle invariants on every edge. Flags stay set when no clear arrives. A clear with no coincident change empties the flags. A coincident change survives a clear. The interrupt latch holds until cleared and never rises without an enabled change. An abort freezes the mask and flags. The pin is never driven high. Only the directed scenarios can show the end-to-end latencies from a pin edge to `live_o`, the flags and the interrupt. They also show the effect of a specific mask pattern, and that an aborted mask write really left the old mask in force.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

    localparam int unsigned DEF_W      = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    // Raw host-side strobes as delivered by the protocol engine
    typedef struct packed {
        logic access;
        logic mask_we;
        logic abort;
    } host_cmd_t;

    // Qualified actions after the abort line has been applied
    typedef struct packed {
        logic clear;
        logic load_mask;
    } host_act_t;

    function automatic host_act_t qualify(input host_cmd_t c);
        host_act_t a;
        a.clear     = c.access  & ~c.abort;
        a.load_mask = c.mask_we & ~c.abort;
        return a;
    endfunction

endpackage

// File: rtl/tdet_sync.sv
module tdet_sync #(
    parameter int unsigned W      = tdet_pkg::DEF_W,
    parameter int unsigned STAGES = tdet_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stage_q[s] <= async_i;
            end else begin : g_next
                always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdet_flags.sv
module tdet_flags
    import tdet_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  host_cmd_t    cmd_i,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] flags_o
);
    host_act_t    act;
    logic [W-1:0] base_q;
    logic [W-1:0] flags_q;

    assign act    = qualify(cmd_i);
    assign diff_o = sync_i ^ base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= sync_i;
            flags_q <= '0;
        end else begin
            base_q  <= sync_i;
            flags_q <= (act.clear ? '0 : flags_q) | diff_o;
        end
    end

    assign flags_o = flags_q;

    // R3
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !act.clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (act.clear && diff_o == '0) |=> (flags_q == '0));

    // R5
    coincide_keep_chk: assert property (@(posedge clk) disable iff (rst)
        act.clear |=> ((flags_q & $past(diff_o)) == $past(diff_o)));

    // R9
    abort_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.abort && diff_o == '0) |=> $stable(flags_q));
endmodule

// File: rtl/tdet_irq.sv
module tdet_irq
    import tdet_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  host_cmd_t    cmd_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] diff_i,
    output logic         irq_o
);
    host_act_t    act;
    logic [W-1:0] mask_q;
    logic         irq_q;
    logic         hit;

    assign act = qualify(cmd_i);
    assign hit = |(diff_i & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            irq_q  <= 1'b0;
        end else begin
            if (act.load_mask) mask_q <= wdata_i;
            irq_q <= (act.clear ? 1'b0 : irq_q) | hit;
        end
    end

    assign irq_o = irq_q;

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !act.clear) |=> irq_q);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((!irq_q || act.clear) && (diff_i & mask_q) == '0) |=> !irq_q);

    // R9
    abort_mask_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_i.abort |=> $stable(mask_q));
endmodule

// File: rtl/tdet_unit.sv
module tdet_unit
    import tdet_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_i,
    input  logic         access_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         abort_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] live_o,
    output logic         irq_n_o
);
    host_cmd_t    cmd;
    logic [W-1:0] sync_v;
    logic [W-1:0] diff_v;
    logic         irq_act;

    assign cmd.access  = access_i;
    assign cmd.mask_we = mask_we_i;
    assign cmd.abort   = abort_i;

    tdet_sync #(.W(W)) sync_i (
        .clk     (clk),
        .async_i (pins_i),
        .sync_o  (sync_v)
    );

    tdet_flags #(.W(W)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .sync_i  (sync_v),
        .diff_o  (diff_v),
        .flags_o (flags_o)
    );

    tdet_irq #(.W(W)) irq_i (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .wdata_i (mask_wdata_i),
        .diff_i  (diff_v),
        .irq_o   (irq_act)
    );

    assign live_o  = sync_v;
    assign irq_n_o = irq_act ? 1'b0 : 1'bz;

    // R10
    never_high_chk: assert property (@(posedge clk) disable iff (rst)
        irq_n_o !== 1'b1);
endmodule

// File: tb/tdet_unit_tb.sv
module tdet_unit_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pins = '0;
    logic         access = 1'b0;
    logic         mask_we = 1'b0;
    logic [W-1:0] mask_wdata = '0;
    logic         abort = 1'b0;
    logic [W-1:0] flags;
    logic [W-1:0] live;
    logic         irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tdet_unit #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .pins_i(pins), .access_i(access),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .abort_i(abort),
        .flags_o(flags), .live_o(live), .irq_n_o(irq_n)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req, input bit low);
        logic exp;
        exp = low ? 1'b0 : 1'bz;
        n_chk++;
        if (irq_n !== exp) begin
            n_bad++;
            $display("FAIL %s: actual irq_n %b expected %b", req, irq_n, exp);
        end
    endtask

    task automatic clear_access();
        access = 1'b1; tick(1); access = 1'b0;
    endtask

    task automatic t_reset();
        chk8("R1 flags", flags, 8'h00);
        chk_irq("R1 irq released", 1'b0);
    endtask

    task automatic t_live_flags();
        pins = pins ^ 8'h81;
        tick(1);
        chk8("R2 live not yet", live, 8'h00);
        tick(1);
        chk8("R2 live", live, 8'h81);
        chk8("R3 flags not yet", flags, 8'h00);
        tick(1);
        chk8("R3 flags set", flags, 8'h81);
        chk_irq("R1/R6 irq via reset mask bit7", 1'b1);
        pins = pins ^ 8'h01;
        tick(3);
        chk8("R3 sticky after return", flags, 8'h81);
        chk_irq("R6 irq held", 1'b1);
        clear_access();
        chk8("R4 flags cleared", flags, 8'h00);
        chk_irq("R4 irq released", 1'b0);
    endtask

    task automatic t_mask();
        mask_wdata = 8'h0F; mask_we = 1'b1; tick(1); mask_we = 1'b0;
        pins = pins ^ 8'h80;
        tick(3);
        chk8("R7 masked flag", flags, 8'h80);
        chk_irq("R7 masked no irq", 1'b0);
        clear_access();
        pins = pins ^ 8'h04;
        tick(3);
        chk8("R8 enabled flag", flags, 8'h04);
        chk_irq("R8 enabled irq", 1'b1);
        clear_access();
        chk_irq("R4 irq released again", 1'b0);
    endtask

    task automatic t_coincide();
        pins = pins ^ 8'h10;
        tick(3);
        chk8("R5 prior flag", flags, 8'h10);
        chk_irq("R7 bit4 masked", 1'b0);
        pins = pins ^ 8'h02;
        tick(2);
        access = 1'b1;
        tick(1);
        access = 1'b0;
        chk8("R5 coincident flag kept", flags, 8'h02);
        chk_irq("R5 coincident irq kept", 1'b1);
        clear_access();
        chk8("R4 empty", flags, 8'h00);
    endtask

    task automatic t_abort();
        pins = pins ^ 8'h04;
        tick(3);
        chk8("R9 pre flags", flags, 8'h04);
        abort = 1'b1; access = 1'b1; mask_we = 1'b1; mask_wdata = 8'h00;
        tick(1);
        abort = 1'b0; access = 1'b0; mask_we = 1'b0;
        chk8("R9 flags kept", flags, 8'h04);
        chk_irq("R9 irq kept", 1'b1);
        clear_access();
        chk_irq("R9 cleared after", 1'b0);
        pins = pins ^ 8'h01;
        tick(3);
        chk8("R9 flag bit0", flags, 8'h01);
        chk_irq("R9 mask unchanged bit0 enabled", 1'b1);
        clear_access();
        chk_irq("R10 released not high", 1'b0);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_live_flags();
        t_mask();
        t_coincide();
        t_abort();
        summary();
    end
endmodule